// File: doc/BRIEF.md
# Double-Buffered Input Capture Channel

This block is a single capture channel of a timer. When an event pulse arrives and capturing is allowed, the block records the current value of a free-running counter. The timestamp first goes into a hidden holding stage. From there it moves into a readable capture register, so the two stages work as a two-entry queue.

Software reads the capture register and pulses a read strobe to consume it. If a value is waiting in the holding stage, that value takes the place of the one just read. A sticky request flag reports that new capture data has arrived. A sticky error flag reports that a timestamp was lost because the holding stage was still occupied.

Capturing needs two enables, one for the event input and one for the channel's capture mode. A channel without capture mode ignores all events.

Top module: `inputCaptureChannel`

## Requirements
- R1: After reset, `capValid`, `pendingFlag`, `irqFlag` and `errFlag` are 0 and `capValue` is 0.
- R2: An event accepted while both stages are empty raises `pendingFlag` after the first clock edge. After the second edge, `capValid` is 1 and `capValue` equals the `counterVal` sampled at the first edge.
- R3: While `capValid` is 1, `capValue` changes only on a read strobe. A read strobe while `pendingFlag` is 1 moves the held timestamp into `capValue` on that same edge, and `capValid` stays 1.
- R4: A read strobe while `pendingFlag` is 0 clears `capValid` at the next edge and leaves `capValue` unchanged.
- R5: An event is accepted only when `evtEnable` and `chanEnable` are both 1 at the clock edge. Otherwise it changes no state or flag.
- R6: An event accepted while `pendingFlag` is 1 is discarded. The held timestamp is kept and `errFlag` is 1 after the edge.
- R7: `irqFlag` becomes 1 on the edge after any cycle in which `pendingFlag` is 1. It stays 1 until a `clrIrq` pulse clears it. A set in the same cycle wins over the clear.
- R8: `errFlag` stays 1 until a `clrErr` pulse clears it. A discard in the same cycle wins over the clear.
- R9: The counter width is the parameter `CNT_W`, 16 by default. All `CNT_W` bits of `counterVal` are stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtEnable | input | 1 | Event-input enable |
| chanEnable | input | 1 | Channel capture-mode enable |
| evtPulse | input | 1 | Capture event, one cycle per event |
| counterVal | input | CNT_W | Free-running counter value to timestamp |
| rdStrobe | input | 1 | Capture register was read; consume it |
| clrIrq | input | 1 | Write-one-to-clear for `irqFlag` |
| clrErr | input | 1 | Write-one-to-clear for `errFlag` |
| capValue | output | CNT_W | Readable capture register |
| capValid | output | 1 | Capture register holds unread data |
| pendingFlag | output | 1 | Hidden stage holds a timestamp |
| irqFlag | output | 1 | Sticky capture request flag |
| errFlag | output | 1 | Sticky overflow error flag |

## Verification
The bench builds the channel with `CNT_W` set to 8. With that width the counter wraps many times during the run, so captured values cover the top bit and cross the wrap point. Directed sequences fill both stages and then force a discard. They also read with and without a held timestamp and collide flag sets with clears. A long stretch of random events, enables, reads and clears then drives the queue through every fill level and checks it against a behavioural model.

// File: rtl/capPkg.sv
package capPkg;
  typedef struct packed {
    logic loadBuf;   // write counter value into hidden stage
    logic moveBuf;   // copy hidden stage into visible register
  } capStrobes_t;
endpackage

// File: rtl/capCtrl.sv
module capCtrl
  import capPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtEnable,
  input  logic        chanEnable,
  input  logic        evtPulse,
  input  logic        rdStrobe,
  input  logic        clrIrq,
  input  logic        clrErr,
  output capStrobes_t strobes,
  output logic        visValid,
  output logic        bufValid,
  output logic        irqFlag,
  output logic        errFlag
);
  logic acceptEvt;
  logic dropEvt;
  logic visFree;

  assign acceptEvt = evtPulse && evtEnable && chanEnable;
  assign dropEvt   = acceptEvt && bufValid;
  assign visFree   = !visValid || rdStrobe;

  always_comb begin
    strobes.loadBuf = acceptEvt && !bufValid;
    strobes.moveBuf = bufValid && visFree;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid <= 1'b0;
      visValid <= 1'b0;
      irqFlag  <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (strobes.loadBuf)      bufValid <= 1'b1;
      else if (strobes.moveBuf) bufValid <= 1'b0;

      if (strobes.moveBuf)      visValid <= 1'b1;
      else if (rdStrobe)        visValid <= 1'b0;

      irqFlag <= (irqFlag && !clrIrq) || bufValid;
      errFlag <= (errFlag && !clrErr) || dropEvt;
    end
  end
endmodule

// File: rtl/capData.sv
module capData
  import capPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobes_t      strobes,
  input  logic [CNT_W-1:0] counterVal,
  output logic [CNT_W-1:0] visData
);
  logic [CNT_W-1:0] bufData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufData <= '0;
      visData <= '0;
    end else begin
      if (strobes.loadBuf) bufData <= counterVal;
      if (strobes.moveBuf) visData <= bufData;
    end
  end
endmodule

// File: rtl/inputCaptureChannel.sv
module inputCaptureChannel
  import capPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtEnable,
  input  logic             chanEnable,
  input  logic             evtPulse,
  input  logic [CNT_W-1:0] counterVal,
  input  logic             rdStrobe,
  input  logic             clrIrq,
  input  logic             clrErr,
  output logic [CNT_W-1:0] capValue,
  output logic             capValid,
  output logic             pendingFlag,
  output logic             irqFlag,
  output logic             errFlag
);
  capStrobes_t strobes;

  capCtrl uCtrl (
    .clk(clk), .rstN(rstN), .evtEnable(evtEnable), .chanEnable(chanEnable),
    .evtPulse(evtPulse), .rdStrobe(rdStrobe), .clrIrq(clrIrq), .clrErr(clrErr),
    .strobes(strobes), .visValid(capValid), .bufValid(pendingFlag),
    .irqFlag(irqFlag), .errFlag(errFlag)
  );

  capData #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .counterVal(counterVal),
    .visData(capValue)
  );
endmodule

// File: rtl/inputCaptureChannelChk.sv
module inputCaptureChannelChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             evtEnable,
  input logic             chanEnable,
  input logic             evtPulse,
  input logic             rdStrobe,
  input logic             clrIrq,
  input logic             clrErr,
  input logic [CNT_W-1:0] capValue,
  input logic             capValid,
  input logic             pendingFlag,
  input logic             irqFlag,
  input logic             errFlag
);
  logic takeEvt;
  assign takeEvt = evtPulse && evtEnable && chanEnable;

  AST_EMPTY_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    takeEvt && !pendingFlag |=> pendingFlag); // R2
  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    capValid && !rdStrobe |=> $stable(capValue)); // R3
  AST_READ_REFILL: assert property (@(posedge clk) disable iff (!rstN)
    pendingFlag && rdStrobe |=> capValid && !pendingFlag); // R3
  AST_READ_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !pendingFlag |=> !capValid && $stable(capValue)); // R4
  AST_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !(evtEnable && chanEnable) && !pendingFlag |=> !pendingFlag); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    takeEvt && pendingFlag |=> errFlag); // R6
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    pendingFlag |=> irqFlag); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !clrIrq |=> irqFlag); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !clrErr |=> errFlag); // R8
endmodule

bind inputCaptureChannel inputCaptureChannelChk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .evtEnable(evtEnable), .chanEnable(chanEnable),
  .evtPulse(evtPulse), .rdStrobe(rdStrobe), .clrIrq(clrIrq), .clrErr(clrErr),
  .capValue(capValue), .capValid(capValid), .pendingFlag(pendingFlag),
  .irqFlag(irqFlag), .errFlag(errFlag)
);

// File: tb/inputCaptureChannel_test.sv
module inputCaptureChannel_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic evtEnable = 1'b0, chanEnable = 1'b0, evtPulse = 1'b0;
  logic rdStrobe = 1'b0, clrIrq = 1'b0, clrErr = 1'b0;
  logic [W-1:0] counterVal = '0;
  logic [W-1:0] capValue;
  logic capValid, pendingFlag, irqFlag, errFlag;

  int checks = 0, failures = 0;
  bit live = 1'b0;

  // behavioural reference state
  bit mBuf, mVis, mIrq, mErr;
  int mBufD, mVisD;

  inputCaptureChannel #(.CNT_W(W)) uut (
    .clk(clk), .rstN(rstN), .evtEnable(evtEnable), .chanEnable(chanEnable),
    .evtPulse(evtPulse), .counterVal(counterVal), .rdStrobe(rdStrobe),
    .clrIrq(clrIrq), .clrErr(clrErr), .capValue(capValue), .capValid(capValid),
    .pendingFlag(pendingFlag), .irqFlag(irqFlag), .errFlag(errFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBuf = 0; mVis = 0; mIrq = 0; mErr = 0; mBufD = 0; mVisD = 0;
    end else begin
      bit ev, mv, nBuf, nVis;
      int nBufD, nVisD;
      ev = evtPulse && evtEnable && chanEnable;
      mv = mBuf && (!mVis || rdStrobe);
      nVis = mv ? 1'b1 : (rdStrobe ? 1'b0 : mVis);
      nVisD = mv ? mBufD : mVisD;
      nBufD = mBufD;
      if (ev && !mBuf) begin nBuf = 1; nBufD = int'(counterVal); end
      else if (mv) nBuf = 0;
      else nBuf = mBuf;
      mIrq = (mIrq && !clrIrq) || mBuf;
      mErr = (mErr && !clrErr) || (ev && mBuf);
      mBuf = nBuf; mBufD = nBufD; mVis = nVis; mVisD = nVisD;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      check(int'(capValue) == mVisD, "R3", "capValue", int'(capValue), mVisD);
      check(capValid == mVis, "R2", "capValid", int'(capValid), int'(mVis));
      check(pendingFlag == mBuf, "R6", "pendingFlag", int'(pendingFlag), int'(mBuf));
      check(irqFlag == mIrq, "R7", "irqFlag", int'(irqFlag), int'(mIrq));
      check(errFlag == mErr, "R8", "errFlag", int'(errFlag), int'(mErr));
    end
  end

  task automatic drive(input bit ev, input bit rd, input bit ci, input bit ce);
    @(negedge clk);
    evtPulse = ev; rdStrobe = rd; clrIrq = ci; clrErr = ce;
    counterVal = counterVal + 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] stampA, stampB;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    live = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!capValid && !pendingFlag && !irqFlag && !errFlag, "R1", "flags",
          int'({capValid, pendingFlag, irqFlag, errFlag}), 0);
    check(capValue == '0, "R1", "capValue", int'(capValue), 0);

    // R5 gating: events with one or both enables low
    evtEnable = 1'b1; chanEnable = 1'b0; drive(1, 0, 0, 0); drive(1, 0, 0, 0);
    evtEnable = 1'b0; chanEnable = 1'b1; drive(1, 0, 0, 0); drive(1, 0, 0, 0);
    drive(0, 0, 0, 0);
    check(!pendingFlag && !capValid && !irqFlag && !errFlag, "R5", "gated state",
          int'({capValid, pendingFlag, irqFlag, errFlag}), 0);

    // R2 single capture through both stages
    evtEnable = 1'b1;
    drive(1, 0, 0, 0); stampA = counterVal;
    drive(0, 0, 0, 0);
    check(pendingFlag, "R2", "pending after first edge", int'(pendingFlag), 1);
    drive(0, 0, 0, 0);
    check(capValid && capValue == stampA, "R2", "capValue", int'(capValue), int'(stampA));
    check(irqFlag, "R7", "irq set", int'(irqFlag), 1);

    // R6 overflow: B held, C discarded
    drive(1, 0, 0, 0); stampB = counterVal;
    drive(1, 0, 0, 0);
    check(pendingFlag, "R6", "pending before drop", int'(pendingFlag), 1);
    drive(0, 0, 0, 0);
    check(errFlag, "R6", "errFlag", int'(errFlag), 1);
    check(capValue == stampA, "R3", "hold without read", int'(capValue), int'(stampA));

    // R3 read refills from hidden stage
    drive(0, 1, 0, 0);
    drive(0, 0, 0, 0);
    check(capValid && capValue == stampB, "R3", "refill", int'(capValue), int'(stampB));
    check(!pendingFlag, "R6", "held stamp kept then moved", int'(pendingFlag), 0);

    // R4 read with hidden stage empty
    drive(0, 1, 0, 0);
    drive(0, 0, 0, 0);
    check(!capValid, "R4", "capValid cleared", int'(capValid), 0);
    check(capValue == stampB, "R4", "value kept", int'(capValue), int'(stampB));

    // R8 / R7 clears
    drive(0, 0, 0, 1);
    drive(0, 0, 1, 0);
    check(!errFlag, "R8", "errFlag cleared", int'(errFlag), 0);
    drive(0, 0, 0, 0);
    check(!irqFlag, "R7", "irqFlag cleared", int'(irqFlag), 0);

    // R9 top counter bit captured
    counterVal = {1'b1, {(W-1){1'b0}}} - 1'b1;
    drive(1, 0, 0, 0); stampA = counterVal;
    drive(0, 0, 0, 0); drive(0, 0, 0, 0);
    check(capValue == stampA && capValue[W-1], "R9", "full width", int'(capValue), int'(stampA));

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      evtEnable = ($urandom % 8) != 0;
      chanEnable = ($urandom % 8) != 0;
      drive(($urandom % 2) == 1, ($urandom % 3) == 0,
            ($urandom % 5) == 0, ($urandom % 6) == 0);
    end
    drive(0, 0, 0, 0);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule